// File: doc/BRIEF.md
# Clock-enable divider bank

The block derives many slower clock enables from one source clock. It holds three groups of dividers: 8-bit integer dividers, 16-bit integer dividers, and fractional dividers with a 24-bit integer part and a 5-bit fraction. Each divider has a programmed integer value N and divides the source by N+1. A fractional divider adds its 5-bit fraction F to an accumulator at the end of every period. When that addition carries, the next period is stretched by one source cycle, so the average ratio is N+1+F/32.

Dividers are started and stopped through a command port. The command names a group code and an index within the group. A select table holds one entry per consumer. Each entry routes any divider's output to that consumer's enable line. Every output is a one-cycle enable pulse in the source clock domain. None of the outputs is a gated clock.

Group codes are the same on every port: 0 for the 8-bit group, 1 for the 16-bit group, 2 for the fractional group, and 3 for no group.

Top module: `clk_div_bank`

## Requirements
- R1: After reset all dividers are stopped, all divider values and fractions are 0, every select entry names group 0 index 0, and every output is low.
- R2: A running 8-bit divider (group 0) with value N, 0 to 255, pulses for one cycle every N+1 cycles. N=0 gives a pulse every cycle.
- R3: A running 16-bit divider (group 1) with value N, 0 to 65535, pulses for one cycle every N+1 cycles.
- R4: A fractional divider (group 2) with integer N and fraction F makes period k, counted from 0 after the enable, last N+2 cycles when floor((k+1)F/32) > floor(kF/32). Otherwise that period lasts N+1 cycles. Any 32 consecutive periods starting at the enable therefore total 32(N+1)+F cycles.
- R5: An enable command clears the divider's count, and its fraction accumulator for group 2. It is accepted at a clock edge E. The first pulse is then high in the cycle after edge E+P, where P is the first period length.
- R6: A disable command accepted at edge E holds that divider's output low from the cycle after E until the divider is enabled again.
- R7: An enable command sent to a divider that is already running restarts it. The next pulse follows the R5 timing measured from the new command.
- R8: A command, configuration write or select entry with group code 3, or with an index beyond its group's size, has no effect. In particular, commands of this kind neither start nor stop any divider.
- R9: Consumer output c equals, in the same cycle, the output of the divider that select entry c names. It is constantly low when the entry names group 3 or an index outside its group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write divider value and fraction |
| cfg_type | input | 2 | Group code of the divider written |
| cfg_idx | input | IW | Index within the group |
| cfg_int | input | 24 | Integer value N (low 8 or 16 bits used for the integer groups) |
| cfg_frac | input | 5 | Fraction F (fractional group only) |
| cmd_valid | input | 1 | Command strobe |
| cmd_en | input | 1 | 1 enables, 0 disables the addressed divider |
| cmd_type | input | 2 | Group code of the command |
| cmd_idx | input | IW | Index of the command |
| sel_we | input | 1 | Write one select table entry |
| sel_cons | input | CW | Consumer whose entry is written |
| sel_type | input | 2 | Group code routed to the consumer |
| sel_idx | input | IW | Divider index routed to the consumer |
| tick_8 | output | N8 | Pulses of the 8-bit dividers |
| tick_16 | output | N16 | Pulses of the 16-bit dividers |
| tick_fr | output | NFR | Pulses of the fractional dividers |
| cons_tick | output | NCONS | Enable pulse of each consumer |

## Verification
A wrong count or limit shows at the ports from the very next pulse. An interval off by one cycle, or a first pulse that comes early, is visible within one period of the enable. An accumulator that is wrong or not cleared changes which periods are stretched. That error appears as a single misplaced long period within the first 32 periods after the enable. A broken select entry shows as a consumer pulse that differs from its divider's pulse in the very cycle it occurs.

// File: rtl/clk_div_bank.sv
module clk_div_bank #(
  parameter int N8    = 4,
  parameter int N16   = 2,
  parameter int NFR   = 2,
  parameter int NCONS = 4,
  parameter int IW    = 3,
  parameter int CW    = (NCONS > 1) ? $clog2(NCONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_type,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [23:0]      cfg_int,
  input  logic [4:0]       cfg_frac,
  input  logic             cmd_valid,
  input  logic             cmd_en,
  input  logic [1:0]       cmd_type,
  input  logic [IW-1:0]    cmd_idx,
  input  logic             sel_we,
  input  logic [CW-1:0]    sel_cons,
  input  logic [1:0]       sel_type,
  input  logic [IW-1:0]    sel_idx,
  output logic [N8-1:0]    tick_8,
  output logic [N16-1:0]   tick_16,
  output logic [NFR-1:0]   tick_fr,
  output logic [NCONS-1:0] cons_tick
);
  localparam int NI = 1 << IW;

  for (genvar i = 0; i < N8; i++) begin : g8
    logic [7:0] div, cnt;
    logic en, t;
    wire hit = cmd_valid && cmd_type == 2'd0 && cmd_idx == IW'(i);
    wire wr  = cfg_we && cfg_type == 2'd0 && cfg_idx == IW'(i);
    wire end_p = cnt == div;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        div <= '0; cnt <= '0; en <= 1'b0; t <= 1'b0;
      end else begin
        if (wr) div <= cfg_int[7:0];
        if (hit) begin
          en <= cmd_en; cnt <= '0; t <= 1'b0;
        end else if (en) begin
          t   <= end_p;
          cnt <= end_p ? 8'd0 : cnt + 8'd1;
        end else t <= 1'b0;
      end
    assign tick_8[i] = t;
  end

  for (genvar i = 0; i < N16; i++) begin : g16
    logic [15:0] div, cnt;
    logic en, t;
    wire hit = cmd_valid && cmd_type == 2'd1 && cmd_idx == IW'(i);
    wire wr  = cfg_we && cfg_type == 2'd1 && cfg_idx == IW'(i);
    wire end_p = cnt == div;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        div <= '0; cnt <= '0; en <= 1'b0; t <= 1'b0;
      end else begin
        if (wr) div <= cfg_int[15:0];
        if (hit) begin
          en <= cmd_en; cnt <= '0; t <= 1'b0;
        end else if (en) begin
          t   <= end_p;
          cnt <= end_p ? 16'd0 : cnt + 16'd1;
        end else t <= 1'b0;
      end
    assign tick_16[i] = t;
  end

  for (genvar i = 0; i < NFR; i++) begin : gfr
    logic [23:0] div;
    logic [24:0] cnt;
    logic [4:0]  fr, acc;
    logic en, t;
    wire hit = cmd_valid && cmd_type == 2'd2 && cmd_idx == IW'(i);
    wire wr  = cfg_we && cfg_type == 2'd2 && cfg_idx == IW'(i);
    wire [5:0]  sum = {1'b0, acc} + {1'b0, fr};
    wire [24:0] lim = {1'b0, div} + {24'd0, sum[5]};
    wire end_p = cnt == lim;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        div <= '0; fr <= '0; cnt <= '0; acc <= '0; en <= 1'b0; t <= 1'b0;
      end else begin
        if (wr) begin
          div <= cfg_int; fr <= cfg_frac;
        end
        if (hit) begin
          en <= cmd_en; cnt <= '0; acc <= '0; t <= 1'b0;
        end else if (en) begin
          t <= end_p;
          if (end_p) begin
            cnt <= '0; acc <= sum[4:0];
          end else cnt <= cnt + 25'd1;
        end else t <= 1'b0;
      end
    assign tick_fr[i] = t;
  end

  wire [NI-1:0] p8  = NI'(tick_8);
  wire [NI-1:0] p16 = NI'(tick_16);
  wire [NI-1:0] pfr = NI'(tick_fr);

  for (genvar c = 0; c < NCONS; c++) begin : gc
    logic [1:0]    st;
    logic [IW-1:0] si;
    wire ok_t = (sel_type == 2'd0 && NI'(sel_idx) < NI'(N8))  ||
                (sel_type == 2'd1 && NI'(sel_idx) < NI'(N16)) ||
                (sel_type == 2'd2 && NI'(sel_idx) < NI'(NFR));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st <= 2'd0; si <= '0;
      end else if (sel_we && sel_cons == CW'(c) && ok_t) begin
        st <= sel_type; si <= sel_idx;
      end
    always_comb
      case (st)
        2'd0:    cons_tick[c] = p8[si];
        2'd1:    cons_tick[c] = p16[si];
        2'd2:    cons_tick[c] = pfr[si];
        default: cons_tick[c] = 1'b0;
      endcase
  end
endmodule

// File: rtl/div_bank_chk.sv
module div_bank_chk #(
  parameter int N8    = 4,
  parameter int N16   = 2,
  parameter int NFR   = 2,
  parameter int NCONS = 4,
  parameter int IW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_en,
  input logic [1:0]       cmd_type,
  input logic [IW-1:0]    cmd_idx,
  input logic [N8-1:0]    tick_8,
  input logic [N16-1:0]   tick_16,
  input logic [NFR-1:0]   tick_fr,
  input logic [NCONS-1:0] cons_tick
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (tick_8 == '0 && tick_16 == '0 && tick_fr == '0 && cons_tick == '0));

  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_en && cmd_type == 2'd0 && cmd_idx == '0) |=> !tick_8[0]);

  // R5
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_en && cmd_type == 2'd2 && cmd_idx == '0) |=> !tick_fr[0]);

  // R9
  cons_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_tick != '0) |-> (tick_8 != '0 || tick_16 != '0 || tick_fr != '0));

  // R8
  bad_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'd3 && tick_8 == '0 && tick_16 == '0 && tick_fr == '0 &&
     $past(tick_8) == '0 && $past(tick_16) == '0 && $past(tick_fr) == '0)
    |=> (tick_8 == '0 && tick_16 == '0 && tick_fr == '0));
endmodule

bind clk_div_bank div_bank_chk #(.N8(N8), .N16(N16), .NFR(NFR), .NCONS(NCONS), .IW(IW)) u_chk (.*);

// File: tb/test_clk_div_bank.sv
module test_clk_div_bank;
  localparam int N8 = 4, N16 = 2, NFR = 2, NCONS = 4, IW = 3, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cmd_valid = 0, cmd_en = 0, sel_we = 0;
  logic [1:0] cfg_type = 0, cmd_type = 0, sel_type = 0;
  logic [IW-1:0] cfg_idx = 0, cmd_idx = 0, sel_idx = 0;
  logic [23:0] cfg_int = 0;
  logic [4:0] cfg_frac = 0;
  logic [CW-1:0] sel_cons = 0;
  logic [N8-1:0] tick_8;
  logic [N16-1:0] tick_16;
  logic [NFR-1:0] tick_fr;
  logic [NCONS-1:0] cons_tick;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  clk_div_bank #(.N8(N8), .N16(N16), .NFR(NFR), .NCONS(NCONS), .IW(IW)) i_clk_div_bank (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic tk(input int t, input int i);
    case (t)
      0: return tick_8[i];
      1: return tick_16[i];
      default: return tick_fr[i];
    endcase
  endfunction

  function automatic int fr_per(input int n, input int f, input int k);
    return n + 1 + ((((k + 1) * f) / 32 != (k * f) / 32) ? 1 : 0);
  endfunction

  task automatic cfg(input int t, input int i, input int n, input int f);
    cfg_we = 1; cfg_type = 2'(t); cfg_idx = IW'(i); cfg_int = 24'(n); cfg_frac = 5'(f);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cmd(input bit en, input int t, input int i);
    cmd_valid = 1; cmd_en = en; cmd_type = 2'(t); cmd_idx = IW'(i);
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic sel(input int c, input int t, input int i);
    sel_we = 1; sel_cons = CW'(c); sel_type = 2'(t); sel_idx = IW'(i);
    @(negedge clk); sel_we = 0;
  endtask

  task automatic wait_pulse(input int t, input int i, input int lim, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tk(t, i) && n < lim);
  endtask

  task automatic quiet();
    for (int i = 0; i < N8; i++) cmd(0, 0, i);
    for (int i = 0; i < N16; i++) cmd(0, 1, i);
    for (int i = 0; i < NFR; i++) cmd(0, 2, i);
  endtask

  task automatic int_run(input int t, input int i, input int n, input string req);
    int got;
    cfg(t, i, n, 0);
    cmd(1, t, i);
    wait_pulse(t, i, n + 10, got);
    chk(got == n + 1, {req, " first pulse"}, got, n + 1);
    for (int k = 0; k < 2; k++) begin
      wait_pulse(t, i, n + 10, got);
      chk(got == n + 1, {req, " interval"}, got, n + 1);
    end
    cmd(0, t, i);
  endtask

  task automatic fr_run(input int i, input int n, input int f, input int nper);
    int got, total;
    total = 0;
    cfg(2, i, n, f);
    cmd(1, 2, i);
    for (int k = 0; k < nper; k++) begin
      wait_pulse(2, i, n + 10, got);
      total += got;
      if (got != fr_per(n, f, k)) chk(0, "R4 period", got, fr_per(n, f, k));
    end
    if (nper == 32) chk(total == 32 * (n + 1) + f, "R4 sum of 32 periods", total, 32 * (n + 1) + f);
    else chk(1, "R4", 0, 0);
    cmd(0, 2, i);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int got, bad, pulses, seed, n;
    seed = 20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: quiet after reset
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick_8 != 0 || tick_16 != 0 || tick_fr != 0 || cons_tick != 0) bad++;
    end
    chk(bad == 0, "R1 outputs low after reset", bad, 0);

    // R2, R5 directed and random 8-bit
    int_run(0, 0, 0, "R2 N=0");
    int_run(0, 0, 1, "R2 N=1");
    int_run(0, 3, 4, "R2 N=4");
    int_run(0, 2, 255, "R2 N=255");
    for (int k = 0; k < 6; k++) int_run(0, $urandom % N8, $urandom % 256, "R5 R2 random");

    // R3 16-bit
    for (int k = 0; k < 3; k++) int_run(1, $urandom % N16, $urandom % 2000, "R3 random");
    cfg(1, 1, 65535, 0);
    cmd(1, 1, 1);
    wait_pulse(1, 1, 70000, got);
    chk(got == 65536, "R3 N=65535 first pulse", got, 65536);
    cmd(0, 1, 1);

    // R4 fractional
    fr_run(0, 3, 0, 32);
    fr_run(1, 2, 31, 32);
    fr_run(0, 0, 1, 32);
    for (int k = 0; k < 4; k++) fr_run($urandom % NFR, $urandom % 7, $urandom % 32, 32);
    fr_run(1, 1000, 17, 3);

    // R6 disable
    cfg(0, 1, 3, 0);
    cmd(1, 0, 1);
    wait_pulse(0, 1, 20, got);
    repeat (2) @(negedge clk);
    cmd(0, 0, 1);
    bad = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (tick_8[1]) bad++; end
    chk(bad == 0, "R6 no pulse after disable", bad, 0);

    // R7 restart while running
    cfg(0, 0, 9, 0);
    cmd(1, 0, 0);
    wait_pulse(0, 0, 20, got);
    repeat (4) @(negedge clk);
    cmd(1, 0, 0);
    wait_pulse(0, 0, 30, got);
    chk(got == 10, "R7 restart first pulse", got, 10);
    cmd(0, 0, 0);

    // R8 invalid commands
    cmd(1, 3, 0);
    cmd(1, 0, 5);
    cmd(1, 1, 3);
    cmd(1, 2, 2);
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tick_8 != 0 || tick_16 != 0 || tick_fr != 0) bad++;
    end
    chk(bad == 0, "R8 invalid enable ignored", bad, 0);
    cfg(0, 0, 2, 0);
    cmd(1, 0, 0);
    wait_pulse(0, 0, 10, got);
    cmd(0, 3, 0);
    cmd(0, 0, 6);
    wait_pulse(0, 0, 10, got);
    chk(got == 1, "R8 invalid disable ignored (pulse one cycle after)", got, 1);
    wait_pulse(0, 0, 10, got);
    chk(got == 3, "R8 cadence kept", got, 3);
    cmd(0, 0, 0);

    // R9 consumer routing
    cfg(0, 1, 2, 0);  cmd(1, 0, 1);
    cfg(1, 0, 4, 0);  cmd(1, 1, 0);
    cfg(2, 1, 1, 13); cmd(1, 2, 1);
    cfg(0, 3, 0, 0);  cmd(1, 0, 3);
    sel(0, 0, 1);
    sel(1, 1, 0);
    sel(2, 2, 1);
    sel(3, 3, 0);
    bad = 0; pulses = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (cons_tick[0] != tick_8[1] || cons_tick[1] != tick_16[0] ||
          cons_tick[2] != tick_fr[1] || cons_tick[3]) bad++;
      pulses += cons_tick[0] + cons_tick[1] + cons_tick[2];
    end
    chk(bad == 0, "R9 consumer follows selected divider", bad, 0);
    chk(pulses > 100, "R9 consumer pulses present", pulses, 101);
    sel(3, 0, 3);
    n = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (cons_tick[3] != 1'b1) n++; end
    chk(n == 0, "R9 consumer on 8-bit divider 3 (N=0)", n, 0);
    sel(3, 0, 6);
    n = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (cons_tick[3] != 1'b1) n++; end
    chk(n == 0, "R8 out-of-range select entry ignored", n, 0);
    quiet();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule